// File: doc/BRIEF.md
# CPU Bus Handover Controller

This block sits in a programmable device beside an 8-bit microprocessor that has no bus request or acknowledge pins. A DMA engine asks for the system bus with a level request. The controller freezes the processor through its ready input. It then floats the processor's address, data and read/write drivers through its bus-enable input, waits a fixed settle time and only then raises a grant. When the request is dropped, it undoes the steps in the opposite order and reports the end of the handover with a one-cycle pulse.

The processor never confirms that its drivers have let go, so the settle counter stands in for that missing acknowledge. A two-bit policy input picks when the takeover may begin:
- at once;
- at an opcode fetch, so a read-modify-write instruction is never split;
- once the processor's memory-lock output is released;
- when both of the last two conditions hold together.

The request, the fetch strobe, the lock output and the phase-2 clock are all asynchronous to the controller. Each passes through two flops before it is used.

Top module: `cpu_bus_handover`

## Requirements
- R1: Reset sets ready and bus enable high, and grant and done low.
- R2: Request, fetch strobe, lock and phase-2 each pass two synchronising flops. In policy 0, ready falls at the fourth rising edge at which the request is sampled high.
- R3: Bus enable is never low while ready is high.
- R4: Ready rises only after bus enable has been high for at least one cycle.
- R5: Grant rises exactly SETTLE_CYCLES cycles after bus enable falls.
- R6: With ready low, bus enable stays high until the synchronised phase-2 clock has been seen high.
- R7: Policy 1 drops ready only while the synchronised fetch strobe is high.
- R8: Policy 2 drops ready only while the synchronised lock output is high (lock released). A low lock level defers the takeover.
- R9: Policy 3 requires the fetch strobe high and the lock released together.
- R10: Policy 0 ignores the fetch strobe and the lock level.
- R11: Grant is high only in the granted state with the synchronised request high. Grant falls in the cycle the synchronised request falls. Bus enable then rises, and ready rises one cycle later.
- R12: Done is a single-cycle pulse, issued with ready and bus enable both high, in the cycle ready is restored.
- R13: A request withdrawn before the bus is floated returns the processor to run without driving bus enable low. If ready had already dropped, a done pulse marks its restoration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, faster than phase-2 |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | Level request from the DMA side (asynchronous) |
| arb_mode | input | 2 | Takeover policy: 0 now, 1 fetch, 2 unlock, 3 both |
| cpu_fetch | input | 1 | Processor opcode-fetch strobe, high on a fetch |
| cpu_lock_n | input | 1 | Processor memory-lock output, low while locked |
| cpu_phi2 | input | 1 | Processor phase-2 clock |
| cpu_rdy | output | 1 | Processor ready control, low halts it |
| cpu_be | output | 1 | Processor bus enable, low floats its buses |
| dma_grant | output | 1 | Bus granted to the DMA side |
| handover_done | output | 1 | One-cycle pulse when ready is restored |

## Verification
The bench builds the controller with SETTLE_CYCLES set to 3. This keeps the float window short enough to cover many full handovers, while still spanning several cycles, so that a grant arriving one cycle early or late breaks the exact R5 spacing. A behavioural model runs alongside and is compared on every cycle. Phase-2 runs as a slow toggle that the bench can stop, which makes the phase-2 wait of R6 and the abort from the halted state reachable. Each policy is driven with its strobes held both blocking and permitting.

// File: rtl/bho_pkg.sv
package bho_pkg;

    typedef enum logic [2:0] {
        HS_IDLE      = 3'd0,
        HS_WAIT_BNDY = 3'd1,
        HS_HALT      = 3'd2,
        HS_FLOAT     = 3'd3,
        HS_GRANTED   = 3'd4,
        HS_RESTORE   = 3'd5,
        HS_RELEASE   = 3'd6
    } hs_state_e;

    typedef enum logic [1:0] {
        POL_NOW    = 2'd0,
        POL_FETCH  = 2'd1,
        POL_UNLOCK = 2'd2,
        POL_BOTH   = 2'd3
    } policy_e;

    typedef struct packed {
        logic rdy;
        logic be;
        logic done;
    } cpu_ctrl_t;

    // Synchroniser bundle layout
    localparam int SB_REQ   = 0;
    localparam int SB_FETCH = 1;
    localparam int SB_LOCKN = 2;
    localparam int SB_PHI2  = 3;
    localparam int SB_W     = 4;
    localparam logic [SB_W-1:0] SB_RESET = 4'b0100;

    function automatic logic boundary_ok(policy_e pol, logic fetch, logic lock_n);
        case (pol)
            POL_NOW:    return 1'b1;
            POL_FETCH:  return fetch;
            POL_UNLOCK: return lock_n;
            default:    return fetch & lock_n;
        endcase
    endfunction

    function automatic cpu_ctrl_t decode_ctrl(hs_state_e st);
        cpu_ctrl_t c;
        c.rdy  = !(st inside {HS_HALT, HS_FLOAT, HS_GRANTED, HS_RESTORE});
        c.be   = !(st inside {HS_FLOAT, HS_GRANTED});
        c.done = (st == HS_RELEASE);
        return c;
    endfunction

endpackage

// File: rtl/bho_sync.sv
module bho_sync #(
    parameter int               W       = 4,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/bho_settle_timer.sv
module bho_settle_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/bho_fsm.sv
module bho_fsm
    import bho_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  policy_e   policy,
    input  logic      req_s,
    input  logic      fetch_s,
    input  logic      lock_n_s,
    input  logic      phi2_s,
    input  logic      settle_done,
    output logic      in_float,
    output logic      rdy,
    output logic      be,
    output logic      grant,
    output logic      done
);
    hs_state_e st, st_nxt;
    cpu_ctrl_t ctrl;

    always_comb begin
        st_nxt = st;
        case (st)
            HS_IDLE:      if (req_s) st_nxt = HS_WAIT_BNDY;
            HS_WAIT_BNDY: begin
                if (!req_s) st_nxt = HS_IDLE;
                else if (boundary_ok(policy, fetch_s, lock_n_s)) st_nxt = HS_HALT;
            end
            HS_HALT: begin
                if (!req_s) st_nxt = HS_RELEASE;
                else if (phi2_s) st_nxt = HS_FLOAT;
            end
            HS_FLOAT:     if (settle_done) st_nxt = HS_GRANTED;
            HS_GRANTED:   if (!req_s) st_nxt = HS_RESTORE;
            HS_RESTORE:   st_nxt = HS_RELEASE;
            HS_RELEASE:   st_nxt = HS_IDLE;
            default:      st_nxt = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= HS_IDLE;
        else     st <= st_nxt;
    end

    assign ctrl     = decode_ctrl(st);
    assign rdy      = ctrl.rdy;
    assign be       = ctrl.be;
    assign done     = ctrl.done;
    assign grant    = (st == HS_GRANTED) && req_s;
    assign in_float = (st == HS_FLOAT);
endmodule

// File: rtl/cpu_bus_handover.sv
module cpu_bus_handover
    import bho_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_req,
    input  logic [1:0] arb_mode,
    input  logic       cpu_fetch,
    input  logic       cpu_lock_n,
    input  logic       cpu_phi2,
    output logic       cpu_rdy,
    output logic       cpu_be,
    output logic       dma_grant,
    output logic       handover_done
);
    logic [SB_W-1:0] raw_bus, syn_bus;
    logic            in_float, settle_done;

    assign raw_bus[SB_REQ]   = dma_req;
    assign raw_bus[SB_FETCH] = cpu_fetch;
    assign raw_bus[SB_LOCKN] = cpu_lock_n;
    assign raw_bus[SB_PHI2]  = cpu_phi2;

    bho_sync #(.W(SB_W), .RST_VAL(SB_RESET)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_bus),
        .q_sync  (syn_bus)
    );

    bho_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (in_float),
        .expired (settle_done)
    );

    bho_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .policy      (policy_e'(arb_mode)),
        .req_s       (syn_bus[SB_REQ]),
        .fetch_s     (syn_bus[SB_FETCH]),
        .lock_n_s    (syn_bus[SB_LOCKN]),
        .phi2_s      (syn_bus[SB_PHI2]),
        .settle_done (settle_done),
        .in_float    (in_float),
        .rdy         (cpu_rdy),
        .be          (cpu_be),
        .grant       (dma_grant),
        .done        (handover_done)
    );
endmodule

// File: rtl/cpu_bus_handover_chk.sv
module cpu_bus_handover_chk #(
    parameter int SETTLE = 4
) (
    input logic clk,
    input logic rst,
    input logic cpu_rdy,
    input logic cpu_be,
    input logic dma_grant,
    input logic handover_done
);
    int be_low_run;

    always_ff @(posedge clk) begin
        if (rst || cpu_be)              be_low_run <= 0;
        else if (be_low_run < SETTLE+1) be_low_run <= be_low_run + 1;
    end

    p_float_needs_halt_r3: assert property (@(posedge clk) disable iff (rst)
        !cpu_be |-> !cpu_rdy);

    p_run_after_drive_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rdy) |-> ($past(cpu_be) && cpu_be));

    p_settle_time_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_grant) |-> (be_low_run == SETTLE));

    p_grant_floated_r11: assert property (@(posedge clk) disable iff (rst)
        dma_grant |-> (!cpu_be && !cpu_rdy));

    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        handover_done |=> !handover_done);

    p_done_running_r12: assert property (@(posedge clk) disable iff (rst)
        handover_done |-> (cpu_rdy && cpu_be));
endmodule

bind cpu_bus_handover cpu_bus_handover_chk #(.SETTLE(SETTLE_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_rdy       (cpu_rdy),
    .cpu_be        (cpu_be),
    .dma_grant     (dma_grant),
    .handover_done (handover_done)
);

// File: tb/cpu_bus_handover_tb.sv
module cpu_bus_handover_tb;
    localparam int SETTLE = 3;

    logic clk = 0, rst = 1;
    logic dma_req = 0, cpu_fetch = 0, cpu_lock_n = 1, cpu_phi2 = 0;
    logic [1:0] arb_mode = 0;
    logic cpu_rdy, cpu_be, dma_grant, handover_done;
    logic phi2_run = 1;
    int   n_tests = 0, n_fail = 0, cyc = 0, phi_div = 0;
    int   done_cnt = 0, grant_cnt = 0, bad_order = 0, be_low_seen = 0;

    always #5 clk = ~clk;

    cpu_bus_handover #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .dma_req(dma_req), .arb_mode(arb_mode),
        .cpu_fetch(cpu_fetch), .cpu_lock_n(cpu_lock_n), .cpu_phi2(cpu_phi2),
        .cpu_rdy(cpu_rdy), .cpu_be(cpu_be), .dma_grant(dma_grant),
        .handover_done(handover_done)
    );

    // phase-2: slow toggle, can be frozen
    always @(negedge clk) begin
        if (phi2_run) begin
            phi_div = phi_div + 1;
            if (phi_div == 2) begin phi_div = 0; cpu_phi2 = ~cpu_phi2; end
        end
    end

    // behavioural reference: step index and delay lines
    int         ms = 0, mcnt = 0;
    logic [3:0] d1 = 4'b0100, d2 = 4'b0100;

    function automatic logic pol_ok(logic [1:0] m, logic f, logic l);
        if (m == 0) return 1;
        if (m == 1) return f;
        if (m == 2) return l;
        return f & l;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mcnt = 0; d1 = 4'b0100; d2 = 4'b0100;
        end else begin
            case (ms)
                0: if (d2[0]) ms = 1;
                1: if (!d2[0]) ms = 0; else if (pol_ok(arb_mode, d2[1], d2[2])) ms = 2;
                2: if (!d2[0]) ms = 6; else if (d2[3]) begin ms = 3; mcnt = 0; end
                3: if (mcnt == SETTLE-1) ms = 4; else mcnt = mcnt + 1;
                4: if (!d2[0]) ms = 5;
                5: ms = 6;
                default: ms = 0;
            endcase
            d2 = d1;
            d1 = {cpu_phi2, cpu_lock_n, cpu_fetch, dma_req};
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // per-cycle compare, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R2 ready", cpu_rdy, !(ms inside {2,3,4,5}));
            chk("R5 bus enable", cpu_be, !(ms inside {3,4}));
            chk("R11 grant", dma_grant, (ms == 4) && d2[0]);
            chk("R12 done", handover_done, ms == 6);
            if (!cpu_be && cpu_rdy) bad_order++;
            if (!cpu_be) be_low_seen++;
            if (handover_done) done_cnt++;
            if (dma_grant) grant_cnt++;
        end
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(1);
        chk("R1 reset ready", cpu_rdy, 1);
        chk("R1 reset be", cpu_be, 1);
        chk("R1 reset grant", dma_grant, 0);
        chk("R1 reset done", handover_done, 0);
        wait_cyc(2); rst = 0; wait_cyc(2);

        // R10: policy 0 ignores strobes (fetch low, locked)
        arb_mode = 0; cpu_fetch = 0; cpu_lock_n = 0;
        dma_req = 1; wait_cyc(6);
        chk("R10 immediate halts", cpu_rdy, 0);
        wait_cyc(12);
        chk("R10 granted", dma_grant, 1);
        dma_req = 0; wait_cyc(8);
        chk("R12 one done", done_cnt == 1, 1);
        cpu_lock_n = 1;

        // R7: fetch boundary
        arb_mode = 1; dma_req = 1; wait_cyc(10);
        chk("R7 deferred", cpu_rdy, 1);
        cpu_fetch = 1; wait_cyc(5); cpu_fetch = 0;
        chk("R7 halted", cpu_rdy, 0);
        wait_cyc(12); dma_req = 0; wait_cyc(8);

        // R8: lock release
        arb_mode = 2; cpu_lock_n = 0; dma_req = 1; wait_cyc(10);
        chk("R8 deferred", cpu_rdy, 1);
        cpu_lock_n = 1; wait_cyc(5);
        chk("R8 halted", cpu_rdy, 0);
        wait_cyc(12); dma_req = 0; wait_cyc(8);

        // R9: both conditions
        arb_mode = 3; cpu_fetch = 1; cpu_lock_n = 0; dma_req = 1; wait_cyc(10);
        chk("R9 fetch only deferred", cpu_rdy, 1);
        cpu_fetch = 0; cpu_lock_n = 1; wait_cyc(8);
        chk("R9 unlock only deferred", cpu_rdy, 1);
        cpu_fetch = 1; wait_cyc(5);
        chk("R9 halted", cpu_rdy, 0);
        wait_cyc(12); dma_req = 0; cpu_fetch = 0; wait_cyc(8);
        chk("R12 four done", done_cnt == 4, 1);
        chk("R11 grants seen", grant_cnt > 0, 1);

        // R6: phase-2 frozen low
        arb_mode = 0; phi2_run = 0; cpu_phi2 = 0; dma_req = 1; wait_cyc(12);
        chk("R6 halted", cpu_rdy, 0);
        chk("R6 not floated", cpu_be, 1);
        cpu_phi2 = 1; wait_cyc(5);
        chk("R6 floated", cpu_be, 0);
        wait_cyc(6); dma_req = 0; wait_cyc(8);

        // R13: abort from halt
        be_low_seen = 0; cpu_phi2 = 0; dma_req = 1; wait_cyc(8);
        dma_req = 0; wait_cyc(8);
        chk("R13 halt abort no float", be_low_seen == 0, 1);
        chk("R13 halt abort done", done_cnt == 6, 1);

        // R13: abort while waiting for a boundary
        phi2_run = 1; arb_mode = 1; cpu_fetch = 0; dma_req = 1; wait_cyc(8);
        dma_req = 0; wait_cyc(8);
        chk("R13 wait abort no float", be_low_seen == 0, 1);
        chk("R13 wait abort ready high", cpu_rdy, 1);
        chk("R13 wait abort no done", done_cnt == 6, 1);

        chk("R3 ordering held", bad_order == 0, 1);
        chk("R4 released idle", cpu_rdy && cpu_be, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule